// File: doc/BRIEF.md
# Multi-Block Read Transfer Sequencer

This block is the card-side controller for reads that span several consecutive blocks. A start pulse gives it the first address, the transfer block length, whether partial blocks are used, whether a partial block may cross a native block boundary, and whether the transfer is open-ended or limited to a preset number of blocks. For each block it checks the address span, issues a single-cycle request on a simple memory read port, and passes each returned word to the data-out interface one cycle later. After each block the address moves on by the block length.

The sequencer reports whether the card is in the transfer state or the data state. A stop command can arrive in any cycle. The sequencer answers it one cycle later, marking the stop illegal when the card was already in the transfer state. Errors found during a transfer do not end the transfer on their own: the block halts, stays in the data state and emits nothing. The error bits appear only in the response to the stop that the host must send. They stay set until a stop response has carried them and then clear.

States: `ST_XFER` (transfer state), `ST_FETCH` (span check and request), `ST_STREAM` (words flowing), `ST_HALT` (stopped on error). Transitions: XFER→FETCH on an accepted start; FETCH→STREAM when the span is clean; FETCH→HALT on an out-of-range or misaligned span; STREAM→FETCH after the last word of a block when more blocks follow; STREAM→XFER after the last word of the final preset block; STREAM→HALT on a memory fault; any state→XFER on a stop.

Top module: `mbr_read_seq`

## Requirements
- R1: After reset the block is in the transfer state (`card_data`=0) with `mem_req`, `dout_valid` and `stop_resp_valid` low. `mem_req` is high only in the data state.
- R2: In open-ended mode, blocks are requested one after another at `start_addr`, `start_addr`+L, `start_addr`+2L and so on, where L is the block length, until a stop arrives. The stop is answered the next cycle with `stop_resp_illegal`=0, and the block is then in the transfer state.
- R3: In preset mode, exactly `start_count` blocks are requested. After the last word of the final block the block returns to the transfer state without a stop.
- R4: A stop received in the transfer state is answered the next cycle with `stop_resp_valid`=1 and `stop_resp_illegal`=1.
- R5: With `start_partial`=0 the block length is 2^NATIVE_LOG2 words; with `start_partial`=1 it is `start_len`. A start is refused, and the block stays in the transfer state, when `start_partial`=1 and `start_len` is 0 or greater than 2^NATIVE_LOG2, or when `start_preset`=1 and `start_count`=0.
- R6: With partial blocks and `start_misalign_ok`=0, a block whose offset within its native block plus its length exceeds 2^NATIVE_LOG2 is not requested. Status bit 1 (address error) is set, and the block halts at the start of that block. With `start_misalign_ok`=1 such blocks are read normally.
- R7: A block whose address plus length exceeds CAPACITY is not requested. Status bit 2 (out of range) is set and the block halts.
- R8: `rd_fault` during streaming sets status bit 0 (internal fault) and halts the block. The faulting cycle produces no data word.
- R9: While halted the block stays in the data state, raises neither `dout_valid` nor `mem_req`, and ignores `rd_valid`, until a stop arrives. The stop is legal and carries the error bits in `stop_resp_status`.
- R10: Error bits accumulate until a stop response reports them and are zero after that response, so the next stop reports `stop_resp_status`=0.
- R11: A word on `rd_valid`/`rd_data` during streaming appears on `dout_valid`/`dout_data` one cycle later. Words arriving in any other state are dropped.
- R12: A stop takes priority over a word or fault arriving in the same cycle; that word is not forwarded. A start arriving while in the data state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start pulse for a new transfer |
| start_addr | input | ADDR_W | First word address |
| start_len | input | LEN_W | Partial block length in words |
| start_partial | input | 1 | Use `start_len` instead of the native length |
| start_misalign_ok | input | 1 | Allow partial blocks across native boundaries |
| start_preset | input | 1 | 1 = preset block count, 0 = open-ended |
| start_count | input | CNT_W | Number of blocks in preset mode |
| stop_valid | input | 1 | Stop command pulse |
| mem_req | output | 1 | Block read request (one cycle) |
| mem_addr | output | ADDR_W | Address of requested block |
| mem_len | output | LEN_W | Length of requested block |
| rd_valid | input | 1 | Memory word valid |
| rd_data | input | DATA_W | Memory word |
| rd_fault | input | 1 | Memory internal fault |
| dout_valid | output | 1 | Data-out word valid |
| dout_data | output | DATA_W | Data-out word |
| card_data | output | 1 | 1 = data state, 0 = transfer state |
| stop_resp_valid | output | 1 | Stop response pulse |
| stop_resp_illegal | output | 1 | Stop was illegal |
| stop_resp_status | output | 3 | Error bits: [2] out of range, [1] address error, [0] internal fault |

## Verification
The hardest case to reach is a halted sequencer that is still being fed by memory. It must stay silent while stray words keep arriving, and the deferred error must come out only on the stop. The bench's memory model goes on delivering the rest of the block after it raises a fault, so the halted state sees live `rd_valid` traffic. Span errors are reached by picking start addresses and partial lengths so that the third block crosses a native boundary or the capacity, while the earlier blocks stay clean.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    typedef enum logic [1:0] {
        ST_XFER   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_STREAM = 2'd2,
        ST_HALT   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic out_of_range;
        logic addr_err;
        logic internal;
    } err_bits_t;

endpackage

// File: rtl/mbr_span_check.sv
module mbr_span_check #(
    parameter int ADDR_W      = 10,
    parameter int NATIVE_LOG2 = 4,
    parameter int LEN_W       = NATIVE_LOG2 + 1,
    parameter int CAPACITY    = 256
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              partial,
    input  logic              misalign_ok,
    output logic              out_of_range,
    output logic              misaligned
);
    localparam int NATIVE = 1 << NATIVE_LOG2;

    logic [ADDR_W:0] span_end;
    assign span_end = {1'b0, addr} + (ADDR_W+1)'(len);

    generate
        if (CAPACITY >= (1 << ADDR_W)) begin : g_full_space
            assign out_of_range = span_end > (ADDR_W+1)'(1 << ADDR_W);
        end else begin : g_limited
            assign out_of_range = span_end > (ADDR_W+1)'(CAPACITY);
        end
    endgenerate

    logic [LEN_W:0] in_block_end;
    assign in_block_end = (LEN_W+1)'(addr[NATIVE_LOG2-1:0]) + (LEN_W+1)'(len);
    assign misaligned   = partial && !misalign_ok && (in_block_end > (LEN_W+1)'(NATIVE));

endmodule

// File: rtl/mbr_beat_counter.sv
module mbr_beat_counter #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign last = (cnt_q == len - LEN_W'(1));

endmodule

// File: rtl/mbr_err_sticky.sv
module mbr_err_sticky
    import mbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  err_bits_t set,
    input  logic      clear,
    output err_bits_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else begin
            q <= q | set;
        end
    end
endmodule

// File: rtl/mbr_read_seq.sv
module mbr_read_seq
    import mbr_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int NATIVE_LOG2 = 4,
    parameter int LEN_W       = NATIVE_LOG2 + 1,
    parameter int CNT_W       = 8,
    parameter int CAPACITY    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              start_partial,
    input  logic              start_misalign_ok,
    input  logic              start_preset,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              stop_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_fault,
    output logic              dout_valid,
    output logic [DATA_W-1:0] dout_data,
    output logic              card_data,
    output logic              stop_resp_valid,
    output logic              stop_resp_illegal,
    output logic [2:0]        stop_resp_status
);
    localparam int NATIVE = 1 << NATIVE_LOG2;

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  rem_q;
    logic              preset_q, partial_q, mok_q;

    logic      span_oor, span_mis, fetch_ok;
    logic      beat_last, beat_step, blk_done;
    logic      len_ok, count_ok, start_ok;
    err_bits_t err_set, err_q;

    // Start acceptance
    assign len_ok   = !start_partial ||
                      ((start_len != '0) && (start_len <= LEN_W'(NATIVE)));
    assign count_ok = !start_preset || (start_count != '0);
    assign start_ok = start_valid && len_ok && count_ok;

    mbr_span_check #(
        .ADDR_W     (ADDR_W),
        .NATIVE_LOG2(NATIVE_LOG2),
        .LEN_W      (LEN_W),
        .CAPACITY   (CAPACITY)
    ) u_span (
        .addr        (addr_q),
        .len         (len_q),
        .partial     (partial_q),
        .misalign_ok (mok_q),
        .out_of_range(span_oor),
        .misaligned  (span_mis)
    );

    assign fetch_ok = (state_q == ST_FETCH) && !span_oor && !span_mis;

    mbr_beat_counter #(.LEN_W(LEN_W)) u_beats (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(fetch_ok),
        .step (beat_step),
        .len  (len_q),
        .last (beat_last)
    );

    mbr_err_sticky u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (err_set),
        .clear(stop_valid),
        .q    (err_q)
    );

    // Next state and control
    always_comb begin
        state_d   = state_q;
        err_set   = '0;
        beat_step = 1'b0;
        blk_done  = 1'b0;
        if (stop_valid) begin
            state_d = ST_XFER;
        end else begin
            unique case (state_q)
                ST_XFER: begin
                    if (start_ok) state_d = ST_FETCH;
                end
                ST_FETCH: begin
                    if (span_oor || span_mis) begin
                        err_set.out_of_range = span_oor;
                        err_set.addr_err     = span_mis;
                        state_d              = ST_HALT;
                    end else begin
                        state_d = ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (rd_fault) begin
                        err_set.internal = 1'b1;
                        state_d          = ST_HALT;
                    end else if (rd_valid) begin
                        beat_step = 1'b1;
                        if (beat_last) begin
                            blk_done = 1'b1;
                            state_d  = (preset_q && (rem_q == CNT_W'(1))) ? ST_XFER : ST_FETCH;
                        end
                    end
                end
                ST_HALT: begin
                    state_d = ST_HALT;
                end
                default: state_d = ST_XFER;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_XFER;
        else        state_q <= state_d;
    end

    // Transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            len_q     <= LEN_W'(NATIVE);
            rem_q     <= '0;
            preset_q  <= 1'b0;
            partial_q <= 1'b0;
            mok_q     <= 1'b0;
        end else if (state_q == ST_XFER && !stop_valid && start_ok) begin
            addr_q    <= start_addr;
            len_q     <= start_partial ? start_len : LEN_W'(NATIVE);
            rem_q     <= start_count;
            preset_q  <= start_preset;
            partial_q <= start_partial;
            mok_q     <= start_misalign_ok;
        end else if (blk_done) begin
            addr_q <= addr_q + ADDR_W'(len_q);
            if (preset_q) rem_q <= rem_q - CNT_W'(1);
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_valid        <= 1'b0;
            dout_data         <= '0;
            stop_resp_valid   <= 1'b0;
            stop_resp_illegal <= 1'b0;
            stop_resp_status  <= '0;
        end else begin
            dout_valid      <= beat_step;
            if (beat_step) dout_data <= rd_data;
            stop_resp_valid <= stop_valid;
            if (stop_valid) begin
                stop_resp_illegal <= (state_q == ST_XFER);
                stop_resp_status  <= err_q;
            end
        end
    end

    assign mem_req   = fetch_ok;
    assign mem_addr  = addr_q;
    assign mem_len   = len_q;
    assign card_data = (state_q != ST_XFER);

endmodule

// File: rtl/mbr_read_seq_checker.sv
module mbr_read_seq_checker
    import mbr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       stop_valid,
    input logic       rd_fault,
    input logic       mem_req,
    input logic       dout_valid,
    input logic       card_data,
    input logic       stop_resp_valid,
    input logic       stop_resp_illegal,
    input seq_state_t state_q,
    input logic [2:0] err_q
);
    assert_req_in_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> card_data);

    assert_legal_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_valid && card_data) |=> (!card_data && stop_resp_valid && !stop_resp_illegal));

    assert_illegal_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_valid && !card_data) |=> (stop_resp_valid && stop_resp_illegal));

    assert_fault_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && rd_fault && !stop_valid) |=> (state_q == ST_HALT && err_q[0]));

    assert_halt_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (!dout_valid && !mem_req));

    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !stop_valid) |=> (state_q == ST_HALT));

    assert_cleared_after_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_resp_valid |-> (err_q == 3'b000));

    assert_idle_no_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !card_data |=> !dout_valid);
endmodule

bind mbr_read_seq mbr_read_seq_checker u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .stop_valid       (stop_valid),
    .rd_fault         (rd_fault),
    .mem_req          (mem_req),
    .dout_valid       (dout_valid),
    .card_data        (card_data),
    .stop_resp_valid  (stop_resp_valid),
    .stop_resp_illegal(stop_resp_illegal),
    .state_q          (state_q),
    .err_q            (err_q)
);

// File: tb/mbr_read_seq_bench.sv
module mbr_read_seq_bench;
    localparam int ADDR_W = 10, DATA_W = 8, NL2 = 4, LEN_W = 5, CNT_W = 8, CAP = 256;
    localparam int NATIVE = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_valid = 0, start_partial = 0, start_misalign_ok = 0, start_preset = 0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  start_len = '0;
    logic [CNT_W-1:0]  start_count = '0;
    logic stop_valid = 0, rd_valid = 0, rd_fault = 0;
    logic [DATA_W-1:0] rd_data = '0;
    logic mem_req, dout_valid, card_data, stop_resp_valid, stop_resp_illegal;
    logic [ADDR_W-1:0] mem_addr;
    logic [LEN_W-1:0]  mem_len;
    logic [DATA_W-1:0] dout_data;
    logic [2:0] stop_resp_status;

    int n_checks = 0, n_errors = 0;

    always #10 clk = ~clk;

    mbr_read_seq u_mbr_read_seq (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .start_len(start_len), .start_partial(start_partial),
        .start_misalign_ok(start_misalign_ok), .start_preset(start_preset),
        .start_count(start_count), .stop_valid(stop_valid), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_len(mem_len), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_fault(rd_fault), .dout_valid(dout_valid), .dout_data(dout_data),
        .card_data(card_data), .stop_resp_valid(stop_resp_valid),
        .stop_resp_illegal(stop_resp_illegal), .stop_resp_status(stop_resp_status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model: 0 transfer, 1 fetch, 2 stream, 3 halted
    int m_state = 0, m_addr = 0, m_len = NATIVE, m_rem = 0, m_beat = 0;
    bit m_preset = 0, m_partial = 0, m_mok = 0;
    bit [2:0] m_err = 0;
    bit e_dv = 0, e_rv = 0, e_ill = 0;
    int e_dd = 0;
    bit [2:0] e_st = 0;

    function automatic bit m_span_bad(output bit oor, output bit mis);
        oor = (m_addr + m_len) > CAP;
        mis = m_partial && !m_mok && ((m_addr % NATIVE) + m_len > NATIVE);
        return oor || mis;
    endfunction

    always @(posedge clk) begin
        bit oor, mis;
        e_dv = 0;
        e_rv = 0;
        if (!rst_n) begin
            m_state = 0; m_err = 0; e_ill = 0; e_st = 0;
        end else if (stop_valid) begin
            e_rv = 1; e_ill = (m_state == 0); e_st = m_err; m_err = 0; m_state = 0;
        end else begin
            case (m_state)
                0: if (start_valid &&
                       (!start_partial || (start_len >= 1 && start_len <= NATIVE)) &&
                       (!start_preset || start_count != 0)) begin
                    m_addr = start_addr; m_len = start_partial ? int'(start_len) : NATIVE;
                    m_rem = start_count; m_preset = start_preset;
                    m_partial = start_partial; m_mok = start_misalign_ok; m_state = 1;
                end
                1: if (m_span_bad(oor, mis)) begin
                    m_err[2] = m_err[2] | oor; m_err[1] = m_err[1] | mis; m_state = 3;
                end else begin
                    m_beat = 0; m_state = 2;
                end
                2: if (rd_fault) begin
                    m_err[0] = 1; m_state = 3;
                end else if (rd_valid) begin
                    e_dv = 1; e_dd = rd_data;
                    if (m_beat == m_len - 1) begin
                        m_addr += m_len;
                        if (m_preset) begin
                            m_rem--; m_state = (m_rem == 0) ? 0 : 1;
                        end else m_state = 1;
                    end else m_beat++;
                end
                default: ;
            endcase
        end
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        bit oor, mis, e_req;
        if (rst_n) begin
            e_req = (m_state == 1) && !m_span_bad(oor, mis);
            check(card_data == (m_state != 0), "R2", "card_data", card_data, m_state != 0);
            check(mem_req == e_req, "R6", "mem_req", mem_req, e_req);
            if (e_req) begin
                check(mem_addr == m_addr, "R2", "mem_addr", mem_addr, m_addr);
                check(mem_len == m_len, "R5", "mem_len", mem_len, m_len);
            end
            check(dout_valid == e_dv, "R11", "dout_valid", dout_valid, e_dv);
            if (e_dv) check(dout_data == e_dd, "R11", "dout_data", dout_data, e_dd);
            check(stop_resp_valid == e_rv, "R4", "stop_resp_valid", stop_resp_valid, e_rv);
            if (e_rv) begin
                check(stop_resp_illegal == e_ill, "R4", "stop_resp_illegal", stop_resp_illegal, e_ill);
                check(stop_resp_status == e_st, "R10", "stop_resp_status", stop_resp_status, e_st);
            end
        end
    end

    // Memory responder: continues the block after a fault
    int pend = 0, sent = 0, cur = 0, cyc = 0, req_idx = 0;
    bit gap_mode = 0, fault_arm = 0;
    int fault_blk = 0, fault_word = 0;
    logic [ADDR_W-1:0] req_q[$];

    always @(negedge clk) begin
        cyc++;
        rd_valid = 0;
        rd_fault = 0;
        if (pend > 0) begin
            if (gap_mode && (cyc % 3 == 1)) begin
            end else if (fault_arm && req_idx == fault_blk && sent == fault_word) begin
                rd_fault = 1; fault_arm = 0;
            end else begin
                rd_valid = 1; rd_data = DATA_W'(cur + sent * 7); sent++; pend--;
            end
        end
        if (mem_req) begin
            pend = mem_len; cur = mem_addr; sent = 0; req_idx++;
            req_q.push_back(mem_addr);
        end
    end

    task automatic go(input int addr, input int len, input bit part, input bit mok,
                      input bit pre, input int cnt);
        @(negedge clk);
        req_q.delete(); req_idx = -1;
        start_valid = 1; start_addr = ADDR_W'(addr); start_len = LEN_W'(len);
        start_partial = part; start_misalign_ok = mok; start_preset = pre;
        start_count = CNT_W'(cnt);
        @(negedge clk);
        start_valid = 0;
    endtask

    task automatic stop_and_check(input bit ill, input int st, input string req);
        @(negedge clk);
        stop_valid = 1;
        @(negedge clk);
        stop_valid = 0;
        check(stop_resp_valid == 1, req, "response present", stop_resp_valid, 1);
        check(stop_resp_illegal == ill, req, "illegal flag", stop_resp_illegal, ill);
        check(stop_resp_status == 3'(st), req, "status", stop_resp_status, st);
        check(card_data == 0, req, "transfer state after stop", card_data, 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_xfer();
        for (int i = 0; i < 600 && card_data; i++) @(negedge clk);
    endtask

    task automatic check_reqs(input int n, input int a0, input int step, input string req);
        check(req_q.size() == n, req, "request count", req_q.size(), n);
        for (int i = 0; i < n && i < req_q.size(); i++)
            check(req_q[i] == ADDR_W'(a0 + i * step), req, "request address", req_q[i], a0 + i * step);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R1", "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int cnt;
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        check(card_data == 0 && mem_req == 0 && dout_valid == 0 && stop_resp_valid == 0,
              "R1", "reset outputs", card_data, 0);

        // R2 open-ended native blocks with memory gaps
        gap_mode = 1;
        go(32, 0, 0, 0, 0, 0);
        idle(70);
        check(card_data == 1, "R2", "still in data state", card_data, 1);
        stop_and_check(0, 0, "R2");
        check(req_q.size() >= 2, "R2", "several blocks", req_q.size(), 2);
        check(req_q[0] == 32 && req_q[1] == 48, "R2", "address advance", req_q[1], 48);
        gap_mode = 0;
        idle(30);

        // R3 preset count, partial length 8
        go(0, 8, 1, 0, 1, 3);
        wait_xfer();
        check_reqs(3, 0, 8, "R3");
        stop_and_check(1, 0, "R3");

        // R4 stop in transfer state
        stop_and_check(1, 0, "R4");

        // R6 misalignment halts at third block
        go(0, 6, 1, 0, 0, 0);
        idle(40);
        check(card_data == 1, "R6", "halted in data state", card_data, 1);
        check_reqs(2, 0, 6, "R6");
        stop_and_check(0, 2, "R6");
        // R10 bits cleared after report
        stop_and_check(1, 0, "R10");

        // R6 misalignment allowed
        go(0, 6, 1, 1, 1, 4);
        wait_xfer();
        check_reqs(4, 0, 6, "R6");

        // R7 out of range
        go(224, 0, 0, 0, 0, 0);
        idle(60);
        check_reqs(2, 224, 16, "R7");
        stop_and_check(0, 4, "R7");
        idle(20);

        // R8 / R9 internal fault with words still arriving
        fault_arm = 1; fault_blk = 1; fault_word = 3;
        go(64, 0, 0, 0, 0, 0);
        for (int i = 0; i < 200 && !rd_fault; i++) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cnt += (dout_valid || mem_req) ? 1 : 0;
        end
        check(cnt == 0, "R9", "silent while halted", cnt, 0);
        check(card_data == 1, "R9", "data state while halted", card_data, 1);
        stop_and_check(0, 1, "R8");
        idle(10);

        // R5 refused starts
        go(0, 0, 1, 0, 0, 0);
        idle(3);
        check(card_data == 0, "R5", "zero length refused", card_data, 0);
        go(0, 17, 1, 0, 0, 0);
        idle(3);
        check(card_data == 0, "R5", "oversize length refused", card_data, 0);
        go(0, 0, 0, 0, 1, 0);
        idle(3);
        check(card_data == 0, "R5", "zero count refused", card_data, 0);

        // R12 start while busy ignored, stop during words
        go(0, 0, 0, 0, 0, 0);
        idle(5);
        @(negedge clk);
        start_valid = 1; start_addr = 100;
        @(negedge clk);
        start_valid = 0;
        idle(25);
        check(req_q.size() >= 2 && req_q[1] == 16, "R12", "busy start ignored", req_q[1], 16);
        stop_and_check(0, 0, "R12");
        check(dout_valid == 0, "R12", "word at stop dropped", dout_valid, 0);
        idle(30);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule